// File: doc/BRIEF.md
# Power Domain Sleep Dependency Controller

This block decides, for every clock domain of a chip with several power domains, when that clock domain's clocks may be switched off. It also decides when each power domain has reached sleep. A clock domain qualifies for gating only when all of the following hold: every initiator module in it is in standby, every target module in it is idle with nothing outstanding, and every power domain that its owning power domain depends on is muted. A power domain is muted when all of its clock domains are muted. A clock domain is muted when each of its public initiators is in standby. An optional companion condition can also count toward muting. It is the idle flag of a partner module that sits elsewhere, such as an interrupt controller paired with a processor.

Clock domains are grouped in fixed blocks of `CD_PER_PD` per power domain. Clock domain `c` belongs to power domain `c / CD_PER_PD`. Software programs two things through one write port: the dependency matrix, and a per-clock-domain public mask. The mask selects which initiator standby flags, plus the companion flag, count toward muting. A power domain reports sleep once all of its clock domains are gated. Every change of that sleep flag is marked by a single-cycle event.

Top module: `sdc_top`

## Requirements
- R1: `cd_gate_en[c]` is 0 whenever any initiator standby flag of clock domain `c` is 0.
- R2: `cd_gate_en[c]` is 0 whenever any target of clock domain `c` has idle = 0 or pending = 1.
- R3: If bit `q` of the dependency row of power domain `p` is 1, then no clock domain of `p` gates unless every clock domain of power domain `q` is muted. A row is written with `cfg_sel` = 0, `cfg_idx` = `p` and `cfg_wdata[N_PD-1:0]`, and takes effect from the next cycle.
- R4: `cd_muted[c]` is 1 exactly when two things hold. First, every initiator `i` with mask bit `i` set has standby 1. Second, if mask bit `N_INIT` is set, `comp_idle[c]` is 1. The mask of `c` is written with `cfg_sel` = 1, `cfg_idx` = `c` and `cfg_wdata[N_INIT:0]`, and takes effect from the next cycle.
- R5: A clock domain whose mask is all zeros is always muted, whatever its inputs.
- R6: Reset clears the dependency matrix and all registered outputs. Each mask resets to all initiator bits set and the companion bit clear.
- R7: `cd_gate_en[c]` is 1 in a cycle exactly when the gating condition (R1, R2, R3) holds in that cycle and also held at the previous clock edge. It falls in the same cycle the condition fails.
- R8: `pd_sleep[p]` goes to 1 one clock after all gate enables of power domain `p` are 1. It goes to 0 one clock after any of them is 0.
- R9: `pd_sleep_evt[p]` is 1 for exactly the cycle in which `pd_sleep[p]` differs from its previous value.
- R10: A write whose `cfg_idx` is not below `N_PD` (dependency) or `N_CD` (mask) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = dependency row, 1 = public mask |
| cfg_idx | input | IDX_W | Row (power domain) or clock domain index |
| cfg_wdata | input | CW | Write data, max(N_PD, N_INIT+1) bits |
| init_stby | input | N_CD*N_INIT | Initiator standby flags, clock domain major |
| tgt_idle | input | N_CD*N_TGT | Target idle flags |
| tgt_pend | input | N_CD*N_TGT | Target pending-transaction flags |
| comp_idle | input | N_CD | Companion module idle per clock domain |
| cd_muted | output | N_CD | Mute status per clock domain |
| cd_gate_en | output | N_CD | Clock-gate enable per clock domain |
| pd_sleep | output | N_PD | Registered sleep-reached flag per power domain |
| pd_sleep_evt | output | N_PD | One-cycle pulse on every sleep flag change |

## Verification
The bench builds the block with two power domains of two clock domains each, two initiators and one target per clock domain, and a three-bit mask. With these values the activity flags of one clock domain can be swept exhaustively. All sixteen dependency matrices and all eight mask values of every clock domain become reachable. Out-of-range dependency indices 2 and 3 exist, so R10 can be exercised. Around these directed sweeps, biased random activity drives the sleep flags in and out of sleep often, which exercises R8 and R9.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [0:0] {
    CFG_DEP  = 1'b0,
    CFG_MASK = 1'b1
  } cfg_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sdc_cfg_regs.sv
module sdc_cfg_regs #(
  parameter int N_PD   = 4,
  parameter int N_CD   = 8,
  parameter int N_INIT = 2,
  parameter int IDX_W  = 3,
  parameter int CW     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [CW-1:0]              cfg_wdata,
  output logic [N_PD*N_PD-1:0]       dep_mat,
  output logic [N_CD*(N_INIT+1)-1:0] mask_flat
);
  import sdc_pkg::*;
  localparam int MW = N_INIT + 1;
  localparam logic [MW-1:0] MASK_RST = {1'b0, {N_INIT{1'b1}}};

  for (genvar p = 0; p < N_PD; p++) begin : g_dep
    wire dep_hit = cfg_we && (cfg_sel == CFG_DEP) && (cfg_idx == IDX_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dep_mat[p*N_PD +: N_PD] <= '0;
      else if (dep_hit) dep_mat[p*N_PD +: N_PD] <= cfg_wdata[N_PD-1:0];
    end
  end

  for (genvar c = 0; c < N_CD; c++) begin : g_mask
    wire mask_hit = cfg_we && (cfg_sel == CFG_MASK) && (cfg_idx == IDX_W'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_flat[c*MW +: MW] <= MASK_RST;
      else if (mask_hit) mask_flat[c*MW +: MW] <= cfg_wdata[MW-1:0];
    end
  end

  a_r6_dep_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (dep_mat == '0));
endmodule

// File: rtl/sdc_cd_gate.sv
module sdc_cd_gate #(
  parameter int N_INIT = 2,
  parameter int N_TGT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] stby_i,
  input  logic [N_TGT-1:0]  idle_i,
  input  logic [N_TGT-1:0]  pend_i,
  input  logic              comp_idle_i,
  input  logic [N_INIT:0]   mask_i,
  input  logic              dep_ok_i,
  output logic              muted_o,
  output logic              gate_en_o
);
  function automatic logic f_local_ok(input logic [N_INIT-1:0] s,
                                      input logic [N_TGT-1:0] idl,
                                      input logic [N_TGT-1:0] pnd);
    return (&s) && (&(idl & ~pnd));
  endfunction

  function automatic logic f_muted(input logic [N_INIT:0] m,
                                   input logic [N_INIT-1:0] s,
                                   input logic ci);
    return &(~m | {ci, s});
  endfunction

  logic local_ok, cond, cond_q;

  assign local_ok  = f_local_ok(stby_i, idle_i, pend_i);
  assign muted_o   = f_muted(mask_i, stby_i, comp_idle_i);
  assign cond      = local_ok && dep_ok_i;
  assign gate_en_o = cond && cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  a_r1_gate_needs_standby: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en_o |-> (&stby_i));
  a_r2_gate_needs_idle_targets: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en_o |-> ((&idle_i) && !(|pend_i)));
  a_r7_gate_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en_o) |-> $past(local_ok && dep_ok_i));
  a_r5_zero_mask_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> muted_o);
endmodule

// File: rtl/sdc_pd_sleep.sv
module sdc_pd_sleep #(
  parameter int CD_PER_PD = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CD_PER_PD-1:0] gate_en_i,
  output logic                 sleep_o,
  output logic                 sleep_evt_o
);
  logic all_gated;
  assign all_gated = &gate_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_o     <= 1'b0;
      sleep_evt_o <= 1'b0;
    end else begin
      sleep_o     <= all_gated;
      sleep_evt_o <= all_gated ^ sleep_o;
    end
  end

  a_r9_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o != $past(sleep_o)) |-> sleep_evt_o);
  a_r9_no_event_when_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o == $past(sleep_o)) |-> !sleep_evt_o);
  a_r8_sleep_tracks_gates: assert property (@(posedge clk) disable iff (!rst_n)
    all_gated |=> sleep_o);
endmodule

// File: rtl/sdc_top.sv
module sdc_top #(
  parameter int N_PD      = 4,
  parameter int CD_PER_PD = 2,
  parameter int N_INIT    = 2,
  parameter int N_TGT     = 2,
  localparam int N_CD  = N_PD * CD_PER_PD,
  localparam int IDX_W = sdc_pkg::idx_width(sdc_pkg::max2(N_PD, N_CD)),
  localparam int CW    = sdc_pkg::max2(N_PD, N_INIT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [CW-1:0]           cfg_wdata,
  input  logic [N_CD*N_INIT-1:0]  init_stby,
  input  logic [N_CD*N_TGT-1:0]   tgt_idle,
  input  logic [N_CD*N_TGT-1:0]   tgt_pend,
  input  logic [N_CD-1:0]         comp_idle,
  output logic [N_CD-1:0]         cd_muted,
  output logic [N_CD-1:0]         cd_gate_en,
  output logic [N_PD-1:0]         pd_sleep,
  output logic [N_PD-1:0]         pd_sleep_evt
);
  localparam int MW = N_INIT + 1;

  logic [N_PD*N_PD-1:0] dep_mat;
  logic [N_CD*MW-1:0]   mask_flat;
  logic [N_PD-1:0]      pd_muted;
  logic [N_PD-1:0]      dep_ok;

  sdc_cfg_regs #(
    .N_PD(N_PD), .N_CD(N_CD), .N_INIT(N_INIT), .IDX_W(IDX_W), .CW(CW)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .dep_mat(dep_mat), .mask_flat(mask_flat)
  );

  for (genvar p = 0; p < N_PD; p++) begin : g_pd
    assign pd_muted[p] = &cd_muted[p*CD_PER_PD +: CD_PER_PD];
    assign dep_ok[p]   = &(~dep_mat[p*N_PD +: N_PD] | pd_muted);

    sdc_pd_sleep #(.CD_PER_PD(CD_PER_PD)) sleep_i (
      .clk(clk), .rst_n(rst_n),
      .gate_en_i(cd_gate_en[p*CD_PER_PD +: CD_PER_PD]),
      .sleep_o(pd_sleep[p]), .sleep_evt_o(pd_sleep_evt[p])
    );
  end

  for (genvar c = 0; c < N_CD; c++) begin : g_cd
    localparam int OWNER = c / CD_PER_PD;

    sdc_cd_gate #(.N_INIT(N_INIT), .N_TGT(N_TGT)) gate_i (
      .clk(clk), .rst_n(rst_n),
      .stby_i(init_stby[c*N_INIT +: N_INIT]),
      .idle_i(tgt_idle[c*N_TGT +: N_TGT]),
      .pend_i(tgt_pend[c*N_TGT +: N_TGT]),
      .comp_idle_i(comp_idle[c]),
      .mask_i(mask_flat[c*MW +: MW]),
      .dep_ok_i(dep_ok[OWNER]),
      .muted_o(cd_muted[c]),
      .gate_en_o(cd_gate_en[c])
    );

    a_r3_depended_domains_muted: assert property (@(posedge clk) disable iff (!rst_n)
      cd_gate_en[c] |-> ((dep_mat[OWNER*N_PD +: N_PD] & ~pd_muted) == '0));
  end
endmodule

// File: tb/sdc_top_tb_top.sv
module sdc_top_tb_top;
  localparam int N_PD = 2, CPP = 2, NI = 2, NT = 1;
  localparam int N_CD = N_PD * CPP;
  localparam int MW = NI + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [2:0] cfg_wdata = '0;
  logic [N_CD*NI-1:0] init_stby = '0;
  logic [N_CD*NT-1:0] tgt_idle = '0, tgt_pend = '0;
  logic [N_CD-1:0] comp_idle = '0;
  logic [N_CD-1:0] cd_muted, cd_gate_en;
  logic [N_PD-1:0] pd_sleep, pd_sleep_evt;

  int n_checks = 0, n_fail = 0;

  logic [N_PD-1:0] m_dep [N_PD];
  logic [MW-1:0]   m_mask [N_CD];
  logic [N_CD-1:0] m_cq;
  logic [N_PD-1:0] m_sleep, m_evt;
  logic [N_CD-1:0] e_muted, e_gate, e_cond;

  always #10 clk = ~clk;

  sdc_top #(.N_PD(N_PD), .CD_PER_PD(CPP), .N_INIT(NI), .N_TGT(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .init_stby(init_stby),
    .tgt_idle(tgt_idle), .tgt_pend(tgt_pend), .comp_idle(comp_idle),
    .cd_muted(cd_muted), .cd_gate_en(cd_gate_en),
    .pd_sleep(pd_sleep), .pd_sleep_evt(pd_sleep_evt)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    logic [N_PD-1:0] pdm, dok;
    for (int c = 0; c < N_CD; c++) begin
      logic mu, lok;
      mu = 1'b1; lok = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (m_mask[c][i] && !init_stby[c*NI+i]) mu = 1'b0;
        if (!init_stby[c*NI+i]) lok = 1'b0;
      end
      if (m_mask[c][NI] && !comp_idle[c]) mu = 1'b0;
      for (int t = 0; t < NT; t++)
        if (!tgt_idle[c*NT+t] || tgt_pend[c*NT+t]) lok = 1'b0;
      e_muted[c] = mu;
      e_cond[c]  = lok;
    end
    for (int p = 0; p < N_PD; p++) begin
      pdm[p] = 1'b1;
      for (int k = 0; k < CPP; k++) if (!e_muted[p*CPP+k]) pdm[p] = 1'b0;
    end
    for (int p = 0; p < N_PD; p++) begin
      dok[p] = 1'b1;
      for (int q = 0; q < N_PD; q++) if (m_dep[p][q] && !pdm[q]) dok[p] = 1'b0;
    end
    for (int c = 0; c < N_CD; c++) begin
      e_cond[c] = e_cond[c] & dok[c/CPP];
      e_gate[c] = e_cond[c] & m_cq[c];
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < N_PD; p++) m_dep[p] = '0;
    for (int c = 0; c < N_CD; c++) m_mask[c] = {1'b0, {NI{1'b1}}};
    m_cq = '0; m_sleep = '0; m_evt = '0;
  endtask

  // inputs are set just after a falling edge; checks at +1, model update at rising edge
  task automatic step(string gtag, string mtag);
    #1;
    model_eval();
    check(mtag, 8'(cd_muted), 8'(e_muted));
    check(gtag, 8'(cd_gate_en), 8'(e_gate));
    check("R8", 8'(pd_sleep), 8'(m_sleep));
    check("R9", 8'(pd_sleep_evt), 8'(m_evt));
    @(posedge clk);
    for (int p = 0; p < N_PD; p++) begin
      logic ns;
      ns = &e_gate[p*CPP +: CPP];
      m_evt[p] = ns ^ m_sleep[p];
      m_sleep[p] = ns;
    end
    m_cq = e_cond;
    if (cfg_we) begin
      if (cfg_sel == 1'b0 && cfg_idx < N_PD) m_dep[cfg_idx] = cfg_wdata[N_PD-1:0];
      if (cfg_sel == 1'b1 && cfg_idx < N_CD) m_mask[cfg_idx] = cfg_wdata[MW-1:0];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_quiet();
    init_stby = '1; tgt_idle = '1; tgt_pend = '0; comp_idle = '1;
  endtask

  task automatic set_random(int busy_pct);
    for (int b = 0; b < N_CD*NI; b++) init_stby[b] = ($urandom % 100) >= busy_pct;
    for (int b = 0; b < N_CD*NT; b++) begin
      tgt_idle[b] = ($urandom % 100) >= busy_pct;
      tgt_pend[b] = ($urandom % 100) < busy_pct / 2;
    end
    for (int b = 0; b < N_CD; b++) comp_idle[b] = ($urandom % 100) >= busy_pct;
  endtask

  task automatic write_cfg(logic sel, logic [1:0] idx, logic [2:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = data;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R6", 8'(cd_gate_en), 8'h00);
    check("R6", 8'(pd_sleep), 8'h00);
    check("R6", 8'(pd_sleep_evt), 8'h00);
    check("R6", 8'(cd_muted), 8'h00);
    rst_n = 1'b1;

    // R1 R2: exhaustive sweep of clock domain 0 activity flags
    for (int v = 0; v < 16; v++) begin
      set_quiet();
      init_stby[1:0] = v[1:0];
      tgt_idle[0] = v[2];
      tgt_pend[0] = v[3];
      for (int k = 0; k < 3; k++) step("R1 R2 R7", "R4");
    end

    // R3: every dependency matrix under biased random activity
    for (int d = 0; d < 16; d++) begin
      write_cfg(1'b0, 2'd0, {1'b0, d[1:0]}); step("R3", "R4");
      write_cfg(1'b0, 2'd1, {1'b0, d[3:2]}); step("R3", "R4");
      for (int k = 0; k < 40; k++) begin
        set_random(8);
        step("R3 R7", "R4");
      end
    end

    // R4 R5: every mask value on every clock domain
    for (int c = 0; c < N_CD; c++) begin
      for (int m = 0; m < 8; m++) begin
        write_cfg(1'b1, 2'(c), 3'(m)); step("R7", "R4");
        for (int k = 0; k < 12; k++) begin
          set_random(30);
          step("R3 R7", (m == 0) ? "R5" : "R4");
        end
      end
      write_cfg(1'b1, 2'(c), 3'b011); step("R7", "R4");
    end

    // R10: out-of-range dependency rows must not alter anything
    write_cfg(1'b0, 2'd0, 3'b000); step("R7", "R4");
    write_cfg(1'b0, 2'd1, 3'b000); step("R7", "R4");
    write_cfg(1'b0, 2'd2, 3'b111); step("R10", "R4");
    write_cfg(1'b0, 2'd3, 3'b111); step("R10", "R4");
    for (int k = 0; k < 30; k++) begin
      set_random(10);
      init_stby[NI*CPP +: NI*CPP] = '0; // power domain 1 never muted
      step("R10", "R4");
    end

    // R8 R9: full quiet into sleep, then wake
    set_quiet();
    for (int k = 0; k < 5; k++) step("R7", "R4");
    check("R8", 8'(pd_sleep), 8'h03);
    init_stby[0] = 1'b0;
    step("R7", "R4");
    step("R7", "R4");
    for (int k = 0; k < 200; k++) begin
      set_random(5);
      step("R7", "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule